// File: doc/BRIEF.md
# Acknowledged Transaction Sequencer

This block is the control state machine that runs a complete acknowledged packet exchange without the host. The host picks a direction with `rx_mode_i`, programs an acknowledgement timeout and pulses `go_set_i`.

In a transmit transaction the sequencer runs these steps in order:
1. It powers the oscillator and waits for it to report stable.
2. It powers the synthesizer and waits for lock.
3. It asks the packet transmitter to send the buffered data packet.
4. It turns the receiver on in acknowledgement mode until an ACK arrives or the timeout runs out.

A status bit then records which of the two ended the exchange.

In a receive transaction it powers up the same way and listens for a data packet. On a valid packet it raises a one-cycle interrupt and captures that packet's 16-bit CRC. It then asks the transmitter for an ACK frame that carries the captured CRC. After the end state it goes back to listening for as long as receive mode stays selected.

The transmitter and receiver engines are outside the block and are reached by request/done handshakes. While an ACK frame is being sent or awaited, a select line tells the engines so. In that phase the data buffers are neither read nor written, and the captured CRC does not change.

Top module: `ack_xact_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `go_pending_o`, every radio enable, every engine request and every status output are 0.
- R2: A `go_set_i` pulse while idle sets `go_pending_o` on the next cycle. One cycle later the transaction starts: `busy_o` goes to 1 and `go_pending_o` clears by itself.
- R3: A `go_set_i` pulse while a transaction is active is ignored. `go_pending_o` stays 0, and once the transaction ends the block stays idle.
- R4: Start-up runs in a fixed order. `osc_en_o` rises first. `syn_en_o` rises only after `osc_ready_i` was seen high. No engine request or receiver enable appears before `syn_lock_i` was seen high.
- R5: In a transmit transaction (`rx_mode_i`=0 at start) the block holds `ptx_req_o`=1 with `ptx_ack_sel_o`=0 until `ptx_done_i`. It then holds `prx_en_o`=1 and `prx_ack_sel_o`=1 for the ACK wait.
- R6: Without an ACK, the ACK wait lasts (T+1)×`TMO_PRESCALE` cycles, where T is `tmo_cycles_i` sampled on entry to the wait. It then ends with `timed_out_o`=1 and `acked_o`=0.
- R7: A `prx_pkt_i` pulse in cycle k of the ACK wait (k counted from 0) ends the wait after k+1 cycles with `acked_o`=1 and `timed_out_o`=0. This also holds when the ACK lands in the final cycle of the window.
- R8: A transaction ends with `xact_done_o` high for exactly one cycle. After a transmit transaction the block is idle in the next cycle.
- R9: In a receive transaction the block listens with `prx_en_o`=1 and `prx_ack_sel_o`=0. The cycle after a `prx_pkt_i` pulse it shows `rx_irq_o`=1 for one cycle, `ptx_req_o`=1 and `ptx_ack_sel_o`=1, with `ack_crc_o` equal to that packet's `prx_crc_i`.
- R10: After the ACK frame's `ptx_done_i`, the end state pulses `xact_done_o`. It then returns to listening if `rx_mode_i` is 1, or goes idle if `rx_mode_i` is 0.
- R11: A packet received during an ACK wait raises no `rx_irq_o` and leaves `ack_crc_o` unchanged. A transmit transaction never flags its data packet as an ACK frame.
- R12: `acked_o` and `timed_out_o` are never both 1, and both clear when a new transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_set_i | input | 1 | Host pulse requesting a transaction |
| rx_mode_i | input | 1 | 1 selects a receive transaction, 0 a transmit transaction |
| tmo_cycles_i | input | TMO_W | ACK wait length T, in prescaled ticks |
| osc_ready_i | input | 1 | Oscillator reports stable |
| syn_lock_i | input | 1 | Synthesizer reports lock |
| ptx_done_i | input | 1 | Transmitter finished the current frame |
| prx_pkt_i | input | 1 | Receiver delivered a valid packet |
| prx_crc_i | input | CRC_W | CRC of the packet just received |
| go_pending_o | output | 1 | GO bit, self-clearing |
| busy_o | output | 1 | A transaction is active |
| osc_en_o | output | 1 | Oscillator enable |
| syn_en_o | output | 1 | Synthesizer enable |
| ptx_req_o | output | 1 | Transmit a frame |
| ptx_ack_sel_o | output | 1 | Frame to send is an ACK, not the data buffer |
| prx_en_o | output | 1 | Receiver enable |
| prx_ack_sel_o | output | 1 | Expected packet is an ACK, not for the data buffer |
| ack_crc_o | output | CRC_W | CRC to place in the outgoing ACK frame |
| rx_irq_o | output | 1 | One-cycle interrupt for a received data packet |
| xact_done_o | output | 1 | One-cycle end-of-transaction pulse |
| acked_o | output | 1 | Last transmit transaction ended by ACK |
| timed_out_o | output | 1 | Last transmit transaction ended by timeout |

## Verification
A wrong state or a wrong timer value shows up at the ports within one cycle of the fault. The length of the receive-enable window during the ACK wait moves by one or more cycles, or the acked/timeout status flips. A broken branch after lock shows up as the wrong request or select line in the cycle right after `syn_lock_i`. A corrupted GO latch shows up two cycles after `go_set_i`, as `busy_o` failing to rise or as a second transaction starting after the end pulse. The sweep pairs every timeout from 0 to 5 with ACK arrival cycles on both sides of the window edge, so off-by-one errors between the ACK and the timeout are exposed.

// File: rtl/axs_pkg.sv
package axs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OSC,
      ST_SYN,
      ST_TXDAT,
      ST_ACKW,
      ST_TXEND,
      ST_RXW,
      ST_RXACK,
      ST_RXEND
   } axs_state_e;

   // oscillator stays powered for the whole transaction
   function automatic logic st_osc_on(axs_state_e s);
      return s != ST_IDLE;
   endfunction

   // synthesizer is powered once the oscillator step is behind us
   function automatic logic st_syn_on(axs_state_e s);
      return (s != ST_IDLE) && (s != ST_OSC);
   endfunction

   function automatic logic st_is_end(axs_state_e s);
      return (s == ST_TXEND) || (s == ST_RXEND);
   endfunction

endpackage

// File: rtl/axs_go_latch.sv
module axs_go_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic idle_i,
   output logic pending_o,
   output logic start_o
);

   assign start_o = pending_o & idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending_o <= 1'b0;
      else if (start_o)
         pending_o <= 1'b0;
      else if (set_i && idle_i)
         pending_o <= 1'b1;
   end

   // R3
   go_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && set_i && !pending_o) |=> !pending_o);

   // R2
   go_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !pending_o);

endmodule

// File: rtl/axs_ack_timer.sv
module axs_ack_timer #(
   parameter int CNT_W    = 8,
   parameter int PRESCALE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);

   logic             tick;
   logic [CNT_W-1:0] cnt;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("axs_ack_timer: CNT_W must be at least 1");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("axs_ack_timer: PRESCALE must be at least 1");
      end

      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_TOP = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] ps;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ps <= '0;
            else if (load_i)
               ps <= PS_TOP;
            else if (run_i)
               ps <= (ps == '0) ? PS_TOP : ps - 1'b1;
         end
         assign tick = (ps == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load_i)
         cnt <= limit_i;
      else if (run_i && tick && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign expire_o = run_i & tick & (cnt == '0);

   // R6
   tmo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt == $past(limit_i)));

   // R6
   tmo_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/axs_seq_fsm.sv
module axs_seq_fsm
   import axs_pkg::*;
#(
   parameter int CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rx_mode_i,
   input  logic             osc_ready_i,
   input  logic             syn_lock_i,
   input  logic             ptx_done_i,
   input  logic             prx_pkt_i,
   input  logic [CRC_W-1:0] prx_crc_i,
   input  logic             expire_i,
   output logic             idle_o,
   output logic             tmr_load_o,
   output logic             tmr_run_o,
   output logic             osc_en_o,
   output logic             syn_en_o,
   output logic             ptx_req_o,
   output logic             ptx_ack_sel_o,
   output logic             prx_en_o,
   output logic             prx_ack_sel_o,
   output logic [CRC_W-1:0] ack_crc_o,
   output logic             rx_irq_o,
   output logic             xact_done_o,
   output logic             acked_o,
   output logic             timed_out_o
);

   axs_state_e st, nxt;
   logic       rx_xact;
   logic       ack_hit;
   logic       rx_take;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE:  if (start_i)     nxt = ST_OSC;
         ST_OSC:   if (osc_ready_i) nxt = ST_SYN;
         ST_SYN:   if (syn_lock_i)  nxt = rx_xact ? ST_RXW : ST_TXDAT;
         ST_TXDAT: if (ptx_done_i)  nxt = ST_ACKW;
         ST_ACKW:  if (prx_pkt_i || expire_i) nxt = ST_TXEND;
         ST_TXEND: nxt = ST_IDLE;
         ST_RXW:   if (prx_pkt_i)   nxt = ST_RXACK;
         ST_RXACK: if (ptx_done_i)  nxt = ST_RXEND;
         ST_RXEND: nxt = rx_mode_i ? ST_RXW : ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= ST_IDLE;
      else
         st <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_xact <= 1'b0;
      else if (start_i)
         rx_xact <= rx_mode_i;
   end

   // an ACK has priority over an expiry in the same cycle
   assign ack_hit = (st == ST_ACKW) && prx_pkt_i;
   assign rx_take = (st == ST_RXW) && prx_pkt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acked_o     <= 1'b0;
         timed_out_o <= 1'b0;
      end else if (start_i) begin
         acked_o     <= 1'b0;
         timed_out_o <= 1'b0;
      end else if (ack_hit) begin
         acked_o <= 1'b1;
      end else if ((st == ST_ACKW) && expire_i) begin
         timed_out_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_crc_o <= '0;
         rx_irq_o  <= 1'b0;
      end else begin
         rx_irq_o <= rx_take;
         if (rx_take)
            ack_crc_o <= prx_crc_i;
      end
   end

   assign idle_o        = (st == ST_IDLE);
   assign tmr_load_o    = (st == ST_TXDAT) && ptx_done_i;
   assign tmr_run_o     = (st == ST_ACKW);
   assign osc_en_o      = st_osc_on(st);
   assign syn_en_o      = st_syn_on(st);
   assign ptx_req_o     = (st == ST_TXDAT) || (st == ST_RXACK);
   assign ptx_ack_sel_o = (st == ST_RXACK);
   assign prx_en_o      = (st == ST_RXW) || (st == ST_ACKW);
   assign prx_ack_sel_o = (st == ST_ACKW);
   assign xact_done_o   = st_is_end(st);

   // R4
   syn_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(syn_en_o) |-> $past(osc_ready_i));

   // R9
   irq_from_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |-> $past(prx_pkt_i));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xact_done_o |=> !xact_done_o);

   // R12
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acked_o && timed_out_o));

   // R11
   ack_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prx_ack_sel_o |=> $stable(ack_crc_o));

   // R11
   ack_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prx_ack_sel_o |=> !rx_irq_o);

endmodule

// File: rtl/ack_xact_seq.sv
module ack_xact_seq #(
   parameter int TMO_W        = 8,
   parameter int TMO_PRESCALE = 1,
   parameter int CRC_W        = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_set_i,
   input  logic             rx_mode_i,
   input  logic [TMO_W-1:0] tmo_cycles_i,
   input  logic             osc_ready_i,
   input  logic             syn_lock_i,
   input  logic             ptx_done_i,
   input  logic             prx_pkt_i,
   input  logic [CRC_W-1:0] prx_crc_i,
   output logic             go_pending_o,
   output logic             busy_o,
   output logic             osc_en_o,
   output logic             syn_en_o,
   output logic             ptx_req_o,
   output logic             ptx_ack_sel_o,
   output logic             prx_en_o,
   output logic             prx_ack_sel_o,
   output logic [CRC_W-1:0] ack_crc_o,
   output logic             rx_irq_o,
   output logic             xact_done_o,
   output logic             acked_o,
   output logic             timed_out_o
);

   generate
      if (CRC_W < 1) begin : g_bad_crc
         $error("ack_xact_seq: CRC_W must be at least 1");
      end
   endgenerate

   logic idle;
   logic start;
   logic tmr_load;
   logic tmr_run;
   logic tmr_expire;

   axs_go_latch i_go (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (go_set_i),
      .idle_i    (idle),
      .pending_o (go_pending_o),
      .start_o   (start)
   );

   axs_ack_timer #(
      .CNT_W    (TMO_W),
      .PRESCALE (TMO_PRESCALE)
   ) i_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .run_i    (tmr_run),
      .limit_i  (tmo_cycles_i),
      .expire_o (tmr_expire)
   );

   axs_seq_fsm #(
      .CRC_W (CRC_W)
   ) i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start),
      .rx_mode_i     (rx_mode_i),
      .osc_ready_i   (osc_ready_i),
      .syn_lock_i    (syn_lock_i),
      .ptx_done_i    (ptx_done_i),
      .prx_pkt_i     (prx_pkt_i),
      .prx_crc_i     (prx_crc_i),
      .expire_i      (tmr_expire),
      .idle_o        (idle),
      .tmr_load_o    (tmr_load),
      .tmr_run_o     (tmr_run),
      .osc_en_o      (osc_en_o),
      .syn_en_o      (syn_en_o),
      .ptx_req_o     (ptx_req_o),
      .ptx_ack_sel_o (ptx_ack_sel_o),
      .prx_en_o      (prx_en_o),
      .prx_ack_sel_o (prx_ack_sel_o),
      .ack_crc_o     (ack_crc_o),
      .rx_irq_o      (rx_irq_o),
      .xact_done_o   (xact_done_o),
      .acked_o       (acked_o),
      .timed_out_o   (timed_out_o)
   );

   assign busy_o = ~idle;

   // R2
   busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_o);

endmodule

// File: tb/test_ack_xact_seq.sv
module test_ack_xact_seq;

   localparam int TW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_set_i = 1'b0;
   logic          rx_mode_i = 1'b0;
   logic [TW-1:0] tmo_cycles_i = '0;
   logic          osc_ready_i = 1'b0;
   logic          syn_lock_i = 1'b0;
   logic          ptx_done_i = 1'b0;
   logic          prx_pkt_i = 1'b0;
   logic [CW-1:0] prx_crc_i = '0;
   logic          go_pending_o, busy_o, osc_en_o, syn_en_o, ptx_req_o, ptx_ack_sel_o;
   logic          prx_en_o, prx_ack_sel_o, rx_irq_o, xact_done_o, acked_o, timed_out_o;
   logic [CW-1:0] ack_crc_o;

   always #4 clk = ~clk;

   ack_xact_seq #(.TMO_W(TW), .TMO_PRESCALE(1), .CRC_W(CW)) i_ack_xact_seq (
      .clk(clk), .rst_n(rst_n), .go_set_i(go_set_i), .rx_mode_i(rx_mode_i),
      .tmo_cycles_i(tmo_cycles_i), .osc_ready_i(osc_ready_i), .syn_lock_i(syn_lock_i),
      .ptx_done_i(ptx_done_i), .prx_pkt_i(prx_pkt_i), .prx_crc_i(prx_crc_i),
      .go_pending_o(go_pending_o), .busy_o(busy_o), .osc_en_o(osc_en_o),
      .syn_en_o(syn_en_o), .ptx_req_o(ptx_req_o), .ptx_ack_sel_o(ptx_ack_sel_o),
      .prx_en_o(prx_en_o), .prx_ack_sel_o(prx_ack_sel_o), .ack_crc_o(ack_crc_o),
      .rx_irq_o(rx_irq_o), .xact_done_o(xact_done_o), .acked_o(acked_o),
      .timed_out_o(timed_out_o));

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // engine model, the only driver of the engine-side inputs
   int  osc_d = 2, syn_d = 3, txd = 4;
   int  ack_at = -1;
   bit  rx_send = 0;
   logic [CW-1:0] rx_crc_val = '0;
   int  oc = 0, sc = 0, tc = 0, wc = 0;
   int  wait_len = 0, irq_cnt = 0;
   bit  osc_ok = 0, syn_ok = 0, order_bad = 0, in_tx = 0, txsel_bad = 0;

   always @(negedge clk) begin
      if (syn_en_o && !osc_ok) order_bad = 1;
      if ((ptx_req_o || prx_en_o) && !syn_ok) order_bad = 1;
      if (osc_en_o) oc++; else begin oc = 0; osc_ok = 0; end
      osc_ready_i = osc_en_o && (oc >= osc_d);
      if (osc_ready_i) osc_ok = 1;
      if (syn_en_o) sc++; else begin sc = 0; syn_ok = 0; end
      syn_lock_i = syn_en_o && (sc >= syn_d);
      if (syn_lock_i) syn_ok = 1;
      if (ptx_req_o) begin
         tc++;
         ptx_done_i = (tc == txd);
         if (in_tx && ptx_ack_sel_o) txsel_bad = 1;
      end else begin
         tc = 0;
         ptx_done_i = 0;
      end
      if (prx_ack_sel_o) begin
         wc++;
         wait_len = wc;
         prx_pkt_i = (ack_at >= 0) && (wc - 1 == ack_at);
         prx_crc_i = 16'hDEAD;
      end else if (rx_send && prx_en_o) begin
         prx_pkt_i = 1;
         prx_crc_i = rx_crc_val;
         rx_send = 0;
      end else begin
         wc = 0;
         prx_pkt_i = 0;
      end
      if (rx_irq_o) irq_cnt++;
   end

   task automatic run_tx(input int t, input int d, input bit poke);
      bit exp_ack;
      int k;
      @(negedge clk);
      tmo_cycles_i = TW'(t); rx_mode_i = 0; ack_at = d; in_tx = 1;
      wait_len = 0; irq_cnt = 0; order_bad = 0; txsel_bad = 0;
      go_set_i = 1;
      @(negedge clk);
      go_set_i = 0;
      check(go_pending_o && !busy_o, "R2 pending", go_pending_o, 1);
      @(negedge clk);
      check(busy_o && !go_pending_o, "R2 start", busy_o, 1);
      check(!acked_o && !timed_out_o, "R12 cleared", acked_o + timed_out_o, 0);
      if (poke) begin
         go_set_i = 1;
         @(negedge clk);
         go_set_i = 0;
         check(!go_pending_o, "R3 ignored", go_pending_o, 0);
      end
      k = 0;
      while (!xact_done_o && k < 500) begin @(negedge clk); k++; end
      exp_ack = (d >= 0) && (d <= t);
      check(k < 500, "R8 end reached", k, 0);
      check(acked_o == exp_ack, "R7 acked", acked_o, exp_ack);
      check(timed_out_o == !exp_ack, "R6 timeout", timed_out_o, !exp_ack);
      check(wait_len == (exp_ack ? d + 1 : t + 1), "R6 R7 window", wait_len,
            exp_ack ? d + 1 : t + 1);
      check(!order_bad, "R4 order", order_bad, 0);
      check(!txsel_bad, "R5 data not ack", txsel_bad, 0);
      check(irq_cnt == 0, "R11 no irq", irq_cnt, 0);
      @(negedge clk);
      check(!xact_done_o && !busy_o, "R8 idle after", busy_o, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         check(!busy_o && !go_pending_o, "R3 no restart", busy_o, 0);
      end
      in_tx = 0;
   endtask

   task automatic run_rx();
      int k;
      logic [CW-1:0] v;
      @(negedge clk);
      rx_mode_i = 1; irq_cnt = 0; order_bad = 0;
      go_set_i = 1;
      @(negedge clk);
      go_set_i = 0;
      for (int i = 0; i < 3; i++) begin
         k = 0;
         while (!(prx_en_o && !prx_ack_sel_o) && k < 100) begin @(negedge clk); k++; end
         check(k < 100 && busy_o, "R9 listening", k, 0);
         v = CW'(16'h1357 * (i + 3));
         rx_crc_val = v;
         rx_send = 1;
         k = 0;
         while (!rx_irq_o && k < 100) begin @(negedge clk); k++; end
         check(rx_irq_o && ptx_req_o && ptx_ack_sel_o, "R9 ack frame", ptx_ack_sel_o, 1);
         check(ack_crc_o == v, "R9 crc copy", int'(ack_crc_o), int'(v));
         if (i == 2) rx_mode_i = 0;
         @(negedge clk);
         check(!rx_irq_o, "R9 irq pulse", rx_irq_o, 0);
         k = 0;
         while (!xact_done_o && k < 100) begin @(negedge clk); k++; end
         check(xact_done_o, "R10 end", xact_done_o, 1);
         @(negedge clk);
         if (i < 2)
            check(prx_en_o && !prx_ack_sel_o && busy_o, "R10 relisten", prx_en_o, 1);
         else
            check(!busy_o && !prx_en_o, "R10 idle", busy_o, 0);
      end
      check(irq_cnt == 3 && !order_bad, "R4 R9 rx count", irq_cnt, 3);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [CW-1:0] last_crc;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!busy_o && !go_pending_o && !osc_en_o && !syn_en_o && !ptx_req_o && !prx_en_o
            && !rx_irq_o && !xact_done_o && !acked_o && !timed_out_o && ack_crc_o == '0,
            "R1 reset", busy_o, 0);
      run_rx();
      last_crc = ack_crc_o;
      for (int t = 0; t <= 5; t++)
         for (int d = -1; d <= 7; d++)
            run_tx(t, d, d == -1 || d == t);
      check(ack_crc_o == last_crc, "R11 crc kept", int'(ack_crc_o), int'(last_crc));
      osc_d = 5; syn_d = 1; txd = 1;
      run_tx(2, 1, 0);
      run_tx(9, -1, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule